// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small record of why the device most recently left reset. Four cause flags live in one 32-bit word. The power-on flag comes up set whenever the block's own reset is applied. The low-power-exit, debug-requested-reset and peripheral-request flags start clear, and each is raised by a single-cycle pulse from the hardware that caused the event.

Software reads the word through a simple synchronous register port. It clears flags by writing ones to them. A zero written to a flag leaves that flag alone. The peripheral-request flag is also driven out of the block, so that other hardware can see it.

Top module: `rcause_status`

## Requirements
- R1: After a synchronous active-low reset, the cause word reads 0x0000_0001 and `rsp_valid` is low.
- R2: A one-cycle pulse on `lowpwr_evt`, `dbg_evt` or `periph_evt` sets bit 1, bit 2 or bit 3 respectively at the next rising clock edge.
- R3: A write to the register address clears every cause bit whose write-data bit is 1. A bit whose write-data bit is 0 keeps its value.
- R4: No input other than reset can set the power-on flag (bit 0). Once it is cleared, it stays clear until the next reset.
- R5: When an event pulse and a software clear of the same bit fall in the same cycle, the bit ends up set.
- R6: Bits 31:4 always read as zero. Writing ones to them has no effect.
- R7: A read request produces `rsp_valid` high one cycle later, with `rsp_rdata` holding the word as it was in the request cycle. Write requests never raise `rsp_valid`.
- R8: `periph_cause` always equals bit 3 of the cause word.
- R9: A write to any other address leaves the cause word unchanged. A read of any other address returns zero, with `rsp_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Word address of the access |
| req_wdata | input | DATA_W (32) | Write data; a 1 in a cause bit clears that bit |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | DATA_W (32) | Read data |
| lowpwr_evt | input | 1 | Pulse: reset came from a low-power exit |
| dbg_evt | input | 1 | Pulse: reset was requested by the debug module |
| periph_evt | input | 1 | Pulse: reset was requested by a peripheral (watchdog, escalation) |
| periph_cause | output | 1 | Current value of the peripheral-request flag |

## Verification
The assertions assume that event inputs are already synchronous to `clk` and that each input is stable around the rising edge. They also assume that at most one access is issued per cycle. The bench changes every input only on the falling edge. It drives events as pulses exactly one cycle wide.

The bench sweeps all eight event combinations against all sixteen clear masks applied in the same cycle. This places the set-versus-clear collisions inside that assumed envelope.

// File: rtl/rcause_pkg.sv
// Package: shared constants for the reset cause register.
// Assumes one 32-bit word holding four cause flags at fixed bit positions.
package rcause_pkg;
    localparam int unsigned NUM_CAUSE = 4;
    localparam int unsigned POR_BIT    = 0;
    localparam int unsigned LOWPWR_BIT = 1;
    localparam int unsigned DBG_BIT    = 2;
    localparam int unsigned PERIPH_BIT = 3;
endpackage

// File: rtl/rcause_bit.sv
// Module: one sticky cause flag.
// It is set by a hardware pulse and cleared by a software write-one.
// A set wins over a clear in the same cycle. Reset loads RST_VAL.
// Assumes set_i and clr_i are synchronous to clk.
module rcause_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Flag register: the hardware set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= RST_VAL;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    AST_SET_WINS:  assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q); // R5
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q)); // R3
endmodule

// File: rtl/rcause_rsp.sv
// Module: read response stage.
// It registers the read data and the valid strobe one cycle after a read request.
// Assumes at most one request per cycle.
// A read that misses the register address returns zero.
module rcause_rsp #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] word_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Response register: capture the word on a hit, zero on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) rsp_rdata <= rd_hit ? word_i : '0;
        end
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid); // R7
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid); // R7
endmodule

// File: rtl/rcause_status.sv
// Module: reset cause status register (top).
// Holds four sticky cause flags, which software reads and clears by writing ones.
// Assumes the event inputs are single-cycle pulses synchronous to clk.
// Assumes full 32-bit accesses with no byte enables.
module rcause_status
    import rcause_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 8,
    parameter int unsigned      DATA_W   = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              lowpwr_evt,
    input  logic              dbg_evt,
    input  logic              periph_evt,
    output logic              periph_cause
);
    localparam int unsigned PAD_W = DATA_W - NUM_CAUSE;

    logic                 addr_hit;
    logic                 wr_hit;
    logic                 rd_req;
    logic [NUM_CAUSE-1:0] set_vec;
    logic [NUM_CAUSE-1:0] cause_q;
    logic [DATA_W-1:0]    cause_word;
    logic                 unused_wdata_hi;

    // Decode: match the register address and split reads from writes.
    always_comb begin
        addr_hit = req_valid && (req_addr == REG_ADDR);
        wr_hit   = addr_hit && req_write;
        rd_req   = req_valid && !req_write;
    end

    // Event routing: the power-on flag has no hardware set path.
    always_comb begin
        set_vec             = '0;
        set_vec[LOWPWR_BIT] = lowpwr_evt;
        set_vec[DBG_BIT]    = dbg_evt;
        set_vec[PERIPH_BIT] = periph_evt;
    end

    for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_cause
        rcause_bit #(
            .RST_VAL(i == POR_BIT)
        ) u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(set_vec[i]),
            .clr_i(wr_hit && req_wdata[i]),
            .q    (cause_q[i])
        );
    end

    assign cause_word      = {{PAD_W{1'b0}}, cause_q};
    assign unused_wdata_hi = ^req_wdata[DATA_W-1:NUM_CAUSE];
    assign periph_cause    = cause_q[PERIPH_BIT];

    rcause_rsp #(
        .DATA_W(DATA_W)
    ) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_hit   (addr_hit),
        .word_i   (cause_word),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    AST_POR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_q[POR_BIT] |=> !cause_q[POR_BIT]); // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[DATA_W-1:NUM_CAUSE] == '0)); // R6
    AST_MISS_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !addr_hit && set_vec == '0) |=> $stable(cause_q)); // R9
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_evt |=> cause_q[DBG_BIT]); // R2
endmodule

// File: tb/sim_rcause_status.sv
module sim_rcause_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        lowpwr_evt = 1'b0;
    logic        dbg_evt = 1'b0;
    logic        periph_evt = 1'b0;
    logic        periph_cause;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rcause_status #(.ADDR_W(8), .DATA_W(32), .REG_ADDR(8'h00)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .lowpwr_evt(lowpwr_evt), .dbg_evt(dbg_evt),
        .periph_evt(periph_evt), .periph_cause(periph_cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        v = rsp_valid; d = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic wr_evt(input logic [7:0] a, input logic [31:0] wd, input logic [2:0] ev, input logic do_wr);
        req_valid = do_wr; req_write = 1'b1; req_addr = a; req_wdata = wd;
        {periph_evt, dbg_evt, lowpwr_evt} = ev;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        {periph_evt, dbg_evt, lowpwr_evt} = 3'b000;
    endtask

    initial begin
        logic [31:0] d;
        logic        v;
        logic [31:0] exp;
        @(negedge clk);
        do_reset();
        chk("R1 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
        rd(8'h00, d, v);
        chk("R1 reset word", d, 32'h1);
        chk("R7 valid after read", {31'b0, v}, 32'h1);
        chk("R8 periph_cause after reset", {31'b0, periph_cause}, 32'h0);

        for (int ev = 0; ev < 8; ev++) begin
            for (int m = 0; m < 16; m++) begin
                do_reset();
                wr_evt(8'h00, 32'h0, 3'b111, 1'b0);
                chk("R8 periph_cause set", {31'b0, periph_cause}, 32'h1);
                rd(8'h00, d, v);
                chk("R2 all events set", d, 32'hF);
                wr_evt(8'h00, {28'hFFFFFFF, 4'(m)}, 3'(ev), 1'b1);
                chk("R7 no rsp after write", {31'b0, rsp_valid}, 32'h0);
                exp = (32'hF & ~32'(m)) | (32'(ev) << 1);
                rd(8'h00, d, v);
                chk("R3 R5 R6 clear vs set", d, exp);
                chk("R8 periph mirror", {31'b0, periph_cause}, {31'b0, exp[3]});
                wr_evt(8'h00, 32'h0, 3'b111, 1'b0);
                rd(8'h00, d, v);
                chk("R4 power-on not set by events", d, exp | 32'hE);
            end
        end

        do_reset();
        wr_evt(8'h00, 32'h0, 3'b010, 1'b0);
        wr_evt(8'h00, 32'h0, 3'b000, 1'b1);
        rd(8'h00, d, v);
        chk("R3 zero write keeps bits", d, 32'h5);
        wr_evt(8'h04, 32'hFFFF_FFFF, 3'b000, 1'b1);
        rd(8'h00, d, v);
        chk("R9 miss write ignored", d, 32'h5);
        rd(8'h04, d, v);
        chk("R9 miss read zero", d, 32'h0);
        chk("R9 miss read valid", {31'b0, v}, 32'h1);
        @(negedge clk);
        chk("R7 valid drops", {31'b0, rsp_valid}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule